// File: doc/BRIEF.md
# Write-Protect Unlock Sequencer

This block stands between the host write port and the page-load controller of a byte-alterable nonvolatile memory. Every host write is presented to it as a one-cycle strobe with its address and data. In the same cycle it answers with one of two outcomes. Either the write may be stored in the page buffer, or it is a command write that must never be stored. A write that gets neither answer is discarded.

The block keeps a protect flag. After reset the flag is clear and ordinary writes pass straight through. A three-write unlock command sets the flag and opens a single page-load window. That window accepts between one and `PAGE_BYTES` data writes. The window closes, and protection takes hold again, in two cases: the page fills, or the host leaves more than `GAP_CYCLES` clock cycles between two writes. The same spacing limit applies between the writes of a command. A six-write clear command removes protection.

The unlock command is 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. The clear command starts with the same first two writes, then sends 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA and 0x20 to 0x5555. The command addresses are parameters, and all address bits are compared.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset the flag is clear and the matcher is idle. With no strobe, both `wr_allow` and `wr_cmd` are 0. A strobed write that is not a command step gives `wr_allow`=1 and `wr_cmd`=0 while the flag is clear.
- R2: A strobed write that matches the next expected command step gives `wr_cmd`=1 and `wr_allow`=0, whether the flag is set or clear. The steps are 0xAA@0x5555, then 0x55@0x2AAA, then 0xA0@0x5555 or 0x80@0x5555, then 0xAA@0x5555, then 0x55@0x2AAA, then 0x20@0x5555.
- R3: The three unlock writes, 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, set the flag and open one page window. This holds whether the flag was clear before or already set.
- R4: While the flag is set and no window is open, a non-command write gives `wr_allow`=0 and `wr_cmd`=0.
- R5: A write that breaks a partly matched command returns the matcher to idle. That write passes only if the flag is clear. If the breaking write is 0xAA@0x5555, it is marked as a command and restarts the sequence at step two.
- R6: Inside an open window every write is a page load: `wr_allow`=1 and `wr_cmd`=0, even when its address and data form a command step. The window closes at once after the `PAGE_BYTES`-th load.
- R7: A strobe that comes exactly `GAP_CYCLES` cycles after the previous one continues a command or a window. A strobe that comes one cycle later finds the matcher idle and the window closed. A window that receives no load closes the same way.
- R8: The six-write clear command clears the flag, and later non-command writes pass.
- R9: The address is compared on all `ADDR_W` bits. Key data at a command address with any single bit flipped is not a command step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle strobe per decoded host write |
| wr_addr | input | ADDR_W | Address of the strobed write |
| wr_data | input | 8 | Data of the strobed write |
| wr_allow | output | 1 | Strobed write may be loaded into the page buffer |
| wr_cmd | output | 1 | Strobed write is a command step and must not be stored |

## Verification
The assertions assume that `wr_stb` is high for exactly one cycle per host write, and that `wr_addr` and `wr_data` hold known values during that cycle. They also assume `rst_n` starts low and is released once. The bench changes every input only on the falling clock edge, issues each write as a single-cycle strobe, and measures each gap as a whole number of cycles from the previous strobe. This places gaps of exactly `GAP_CYCLES` and one cycle more at known positions.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef logic [7:0] wp_byte_t;

    // command key bytes
    localparam wp_byte_t KEY_A    = 8'hAA;
    localparam wp_byte_t KEY_B    = 8'h55;
    localparam wp_byte_t OP_OPEN  = 8'hA0;
    localparam wp_byte_t OP_ERASE = 8'h80;
    localparam wp_byte_t OP_CLEAR = 8'h20;

    // number of command writes already matched
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_E1   = 3'd3,
        ST_E2   = 3'd4,
        ST_E3   = 3'd5
    } wp_step_e;

endpackage

// File: rtl/wp_key_match.sv
module wp_key_match
    import wp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] ADDR_X = 16'h5555,
    parameter logic [ADDR_W-1:0] ADDR_Y = 16'h2AAA
) (
    input  wp_step_e          step,
    input  logic [ADDR_W-1:0] addr,
    input  wp_byte_t          data,
    output logic              adv,
    output wp_step_e          next_step,
    output logic              hit_open,
    output logic              hit_clear,
    output logic              hit_first
);

    logic at_x;
    logic at_y;

    always_comb begin
        at_x      = (addr == ADDR_X);
        at_y      = (addr == ADDR_Y);
        hit_first = at_x && (data == KEY_A);
        adv       = 1'b0;
        next_step = ST_IDLE;
        hit_open  = 1'b0;
        hit_clear = 1'b0;
        unique case (step)
            ST_IDLE: begin
                adv       = hit_first;
                next_step = ST_K1;
            end
            ST_K1: begin
                adv       = at_y && (data == KEY_B);
                next_step = ST_K2;
            end
            ST_K2: begin
                if (at_x && (data == OP_OPEN)) begin
                    adv       = 1'b1;
                    hit_open  = 1'b1;
                    next_step = ST_IDLE;
                end else if (at_x && (data == OP_ERASE)) begin
                    adv       = 1'b1;
                    next_step = ST_E1;
                end
            end
            ST_E1: begin
                adv       = hit_first;
                next_step = ST_E2;
            end
            ST_E2: begin
                adv       = at_y && (data == KEY_B);
                next_step = ST_E3;
            end
            ST_E3: begin
                adv       = at_x && (data == OP_CLEAR);
                hit_clear = adv;
                next_step = ST_IDLE;
            end
            default: begin
                adv       = 1'b0;
                next_step = ST_IDLE;
            end
        endcase
    end

    // R2: open and clear are each the final step of their own command
    always_comb begin
        assert_final_steps_R2: assert (!(hit_open && hit_clear));
    end

endmodule

// File: rtl/wp_gap_timer.sv
module wp_gap_timer #(
    parameter int GAP_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);

    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        expire = 1'b0;
        cnt_d  = '0;
        if (kick || !run) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(GAP_CYCLES - 1)) begin
            expire = 1'b1;
            cnt_d  = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(GAP_CYCLES));

    assert_kick_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0));

endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 128,
    parameter int GAP_CYCLES = 5000,
    parameter logic [ADDR_W-1:0] ADDR_X = 16'h5555,
    parameter logic [ADDR_W-1:0] ADDR_Y = 16'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wr_allow,
    output logic              wr_cmd
);

    localparam int LW = $clog2(PAGE_BYTES + 1);

    typedef struct packed {
        logic            prot;
        wp_step_e        step;
        logic            win;
        logic [LW-1:0]   loads;
    } seq_state_t;

    seq_state_t st_d;
    seq_state_t st_q;

    logic     m_adv;
    wp_step_e m_next;
    logic     m_open;
    logic     m_clear;
    logic     m_first;
    logic     tmr_run;
    logic     tmr_expire;

    wp_key_match #(
        .ADDR_W (ADDR_W),
        .ADDR_X (ADDR_X),
        .ADDR_Y (ADDR_Y)
    ) i_match (
        .step      (st_q.step),
        .addr      (wr_addr),
        .data      (wr_data),
        .adv       (m_adv),
        .next_step (m_next),
        .hit_open  (m_open),
        .hit_clear (m_clear),
        .hit_first (m_first)
    );

    assign tmr_run = (st_q.step != ST_IDLE) || st_q.win;

    wp_gap_timer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .kick   (wr_stb),
        .expire (tmr_expire)
    );

    always_comb begin
        st_d     = st_q;
        wr_allow = 1'b0;
        wr_cmd   = 1'b0;
        if (wr_stb) begin
            if (st_q.win) begin
                wr_allow = 1'b1;
                if (st_q.loads == LW'(PAGE_BYTES - 1)) begin
                    st_d.win   = 1'b0;
                    st_d.loads = '0;
                end else begin
                    st_d.loads = st_q.loads + 1'b1;
                end
            end else if (m_adv) begin
                wr_cmd    = 1'b1;
                st_d.step = m_next;
                if (m_open) begin
                    st_d.prot  = 1'b1;
                    st_d.win   = 1'b1;
                    st_d.loads = '0;
                end
                if (m_clear) begin
                    st_d.prot = 1'b0;
                end
            end else if (m_first) begin
                wr_cmd    = 1'b1;
                st_d.step = ST_K1;
            end else begin
                wr_allow  = !st_q.prot;
                st_d.step = ST_IDLE;
            end
        end else if (tmr_expire) begin
            st_d.step  = ST_IDLE;
            st_d.win   = 1'b0;
            st_d.loads = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prot: 1'b0, step: ST_IDLE, win: 1'b0, loads: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_quiet_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> !(wr_allow || wr_cmd));

    assert_pass_when_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !st_q.prot && !wr_cmd) |-> wr_allow);

    assert_cmd_never_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |-> !wr_allow);

    assert_window_implies_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.win) |-> st_q.prot);

    assert_block_when_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && st_q.prot && !st_q.win && !wr_cmd) |-> !wr_allow);

    assert_window_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && st_q.win) |-> (wr_allow && !wr_cmd));

    assert_load_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.win |-> (st_q.loads < LW'(PAGE_BYTES)));

    assert_expire_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire |=> ((st_q.step == ST_IDLE) && !st_q.win));

endmodule

// File: tb/test_wp_unlock_seq.sv
`timescale 1ns/1ps
module test_wp_unlock_seq;

    localparam int GAP  = 6;
    localparam int PAGE = 4;
    localparam logic [15:0] AX  = 16'h5555;
    localparam logic [15:0] AY  = 16'h2AAA;
    localparam logic [15:0] DAT = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_allow;
    logic        wr_cmd;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wp_unlock_seq #(
        .ADDR_W     (16),
        .PAGE_BYTES (PAGE),
        .GAP_CYCLES (GAP),
        .ADDR_X     (AX),
        .ADDR_Y     (AY)
    ) i_wp_unlock_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_allow (wr_allow),
        .wr_cmd   (wr_cmd)
    );

    task automatic check(string tag, logic ea, logic ec);
        n_chk++;
        if (wr_allow !== ea || wr_cmd !== ec) begin
            n_err++;
            $display("FAIL %s: allow/cmd actual %b/%b expected %b/%b",
                     tag, wr_allow, wr_cmd, ea, ec);
        end
    endtask

    // strobe a write d cycles after the previous strobe
    task automatic wr(int d, logic [15:0] a, logic [7:0] v,
                      logic ea, logic ec, string tag);
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            wr_stb = (i == d - 1);
            if (i == d - 1) begin
                wr_addr = a;
                wr_data = v;
            end
        end
        #1;
        check(tag, ea, ec);
    endtask

    task automatic unlock(int d, string tag);
        wr(1, AX, 8'hAA, 1'b0, 1'b1, tag);
        wr(d, AY, 8'h55, 1'b0, 1'b1, tag);
        wr(d, AX, 8'hA0, 1'b0, 1'b1, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 idle after reset", 1'b0, 1'b0);
        wr(1, DAT, 8'h12, 1'b1, 1'b0, "R1 write passes unprotected");

        // R2/R5 sweep of every data byte at the first key address, unprotected
        for (int v = 0; v < 256; v++) begin
            wr(1, AX, 8'(v), (v != 8'hAA), (v == 8'hAA), "R2 R5 unprotected sweep");
        end

        // R9: each single flipped address bit defeats the key
        for (int b = 0; b < 16; b++) begin
            wr(1, AX ^ (16'h1 << b), 8'hAA, 1'b1, 1'b0, "R9 address bit flip");
        end
        wr(1, AY ^ 16'h8000, 8'h55, 1'b1, 1'b0, "R9 second address high bit");

        // R3: first unlock sets flag and opens window; R6 keys load as data
        unlock(1, "R3 unlock from clear");
        wr(1, AX, 8'hAA, 1'b1, 1'b0, "R6 key byte loads as data");
        wr(1, DAT, 8'h34, 1'b1, 1'b0, "R6 second load");
        wr(GAP + 1, DAT, 8'h56, 1'b0, 1'b0, "R7 R4 window closed by gap");

        // R4/R2/R5 sweep while protected
        for (int v = 0; v < 256; v++) begin
            wr(1, AX, 8'(v), 1'b0, (v == 8'hAA), "R4 R2 protected sweep");
        end

        // R7: gap boundary inside a command
        wr(1, AX, 8'hAA, 1'b0, 1'b1, "R7 cmd step one");
        wr(GAP, AY, 8'h55, 1'b0, 1'b1, "R7 cmd step at full gap");
        wr(GAP + 1, AX, 8'hA0, 1'b0, 1'b0, "R7 cmd step after gap lost");
        unlock(GAP, "R7 unlock at full gaps");
        wr(GAP, DAT, 8'h11, 1'b1, 1'b0, "R7 load at full gap");
        wr(GAP, DAT, 8'h22, 1'b1, 1'b0, "R7 load at full gap again");
        wr(GAP + 1, DAT, 8'h33, 1'b0, 1'b0, "R7 load after gap");

        // R7: empty window closes
        unlock(1, "R3 unlock while protected");
        wr(GAP + 1, DAT, 8'h44, 1'b0, 1'b0, "R7 empty window closes");

        // R6/R3: window sizes 1..PAGE, each after a fresh unlock
        for (int n = 1; n <= PAGE; n++) begin
            unlock(1, "R3 unlock per window");
            for (int k = 0; k < n; k++) begin
                wr(1, DAT + 16'(k), 8'(k), 1'b1, 1'b0, "R6 page load");
            end
            if (n == PAGE) wr(1, DAT, 8'h99, 1'b0, 1'b0, "R6 full page closes window");
            else           wr(GAP + 1, DAT, 8'h99, 1'b0, 1'b0, "R6 partial page closes by gap");
        end

        // R5: restart and break while protected
        wr(1, AX, 8'hAA, 1'b0, 1'b1, "R5 first key");
        wr(1, AX, 8'hAA, 1'b0, 1'b1, "R5 repeated first key restarts");
        wr(1, AY, 8'h55, 1'b0, 1'b1, "R5 second key after restart");
        wr(1, AX, 8'hA0, 1'b0, 1'b1, "R5 open after restart");
        wr(1, DAT, 8'h5A, 1'b1, 1'b0, "R5 load after restarted unlock");
        wr(GAP + 1, AX, 8'hAA, 1'b0, 1'b1, "R5 first key again");
        wr(1, AY, 8'h12, 1'b0, 1'b0, "R5 wrong data breaks");
        wr(1, AY, 8'h55, 1'b0, 1'b0, "R5 second key alone rejected");
        wr(1, AX, 8'hA0, 1'b0, 1'b0, "R5 open alone rejected");
        wr(1, DAT, 8'h77, 1'b0, 1'b0, "R5 no window after break");

        // R8: clear command
        wr(1, AX, 8'hAA, 1'b0, 1'b1, "R8 clear step 1");
        wr(1, AY, 8'h55, 1'b0, 1'b1, "R8 clear step 2");
        wr(1, AX, 8'h80, 1'b0, 1'b1, "R8 clear step 3");
        wr(1, AX, 8'hAA, 1'b0, 1'b1, "R8 clear step 4");
        wr(1, AY, 8'h55, 1'b0, 1'b1, "R8 clear step 5");
        wr(1, AX, 8'h20, 1'b0, 1'b1, "R8 clear step 6");
        wr(1, DAT, 8'h33, 1'b1, 1'b0, "R8 write passes after clear");
        wr(GAP + 1, AX, 8'hA0, 1'b1, 1'b0, "R8 R1 non-command passes");
        @(negedge clk);
        wr_stb = 1'b0;
        #1;
        check("R1 quiet after last strobe", 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule